// File: doc/BRIEF.md
# Sleep-Type Control and Event Routing Register

This block holds the platform's sleep-type selection and the routing choice for power-management events. Software writes a control word over a small synchronous register bus. The block stores a 3-bit sleep code from that word and decodes it into four level outputs: a processor clock-stop request, a processor sleep request, a suspend-to-RAM request and a suspend-to-disk/soft-off request. Only the five defined codes produce sleep outputs. The three reserved codes are stored exactly as written and read back unchanged, but they decode as the running state.

The same word carries two more fields. A routing bit decides whether the thermal and timer events on the event inputs raise a system-control interrupt request or a system-management interrupt request. A write-only release bit raises a firmware system-management request. Both interrupt requests are single-cycle pulses. Power sequencing, firmware behaviour and power rails lie outside this block, which only drives levels and pulses.

Top module: `slp_type_ctrl`

## Requirements
- R1: After reset the stored sleep code is 000 and the routing bit is 0. All sleep outputs and both request outputs are low, and a read of the control word returns 0.
- R2: Sleep code 001 drives only `clk_stop_o` high.
- R3: Sleep code 010 drives `clk_stop_o` and `cpu_sleep_o` high and the other two sleep outputs low.
- R4: Sleep code 011 drives only `susp_ram_o` high.
- R5: Sleep code 100 drives only `soft_off_o` high. Sleep code 000 drives all four sleep outputs low.
- R6: Sleep codes 101, 110 and 111 drive all four sleep outputs low. A read returns the reserved code exactly as written.
- R7: The control word sits at address 0. Bit 0 is the routing bit, bit 1 is the release bit and bits 6:4 are the sleep code. A write with bit 1 set makes `smi_req_o` high for exactly the one cycle after the write edge, whatever the routing bit holds. Bit 1 always reads as 0.
- R8: When the routing bit is 1, a rising edge on any event input makes `sci_req_o` high for one cycle after the sampling edge, and `smi_req_o` stays low.
- R9: When the routing bit is 0, a rising edge on any event input makes `smi_req_o` high for one cycle, and `sci_req_o` stays low.
- R10: A write to any address other than 0 leaves the stored fields unchanged. A read of any address other than 0 returns 0.
- R11: An event input held high produces only one request pulse. It produces another only after it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register bus |
| addr | input | AW (2) | Register address for reads and writes |
| wr_data | input | DW (16) | Write data |
| rd_data | output | DW (16) | Read data for `addr`, valid in the same cycle |
| evt_in | input | EVT_N (2) | Event inputs (thermal, timer) |
| clk_stop_o | output | 1 | Processor clock-stop request |
| cpu_sleep_o | output | 1 | Processor sleep request |
| susp_ram_o | output | 1 | Suspend-to-RAM request |
| soft_off_o | output | 1 | Suspend-to-disk / soft-off request |
| sci_req_o | output | 1 | System-control interrupt request pulse |
| smi_req_o | output | 1 | System-management interrupt request pulse |

## Verification
The assertions assume that the bus and event inputs change only away from the active clock edge. They also assume the block sees only its own write strobe and no other source of stored state. The stimulus drives every input on the falling edge and samples results on later falling edges. It issues each write as one strobe cycle and each event as a clean rising edge, so every request pulse can be traced to a single write or edge.

// File: rtl/slp_type_pkg.sv
package slp_type_pkg;
   localparam int ROUTE_BIT = 0;
   localparam int REL_BIT   = 1;
   localparam int CODE_LSB  = 4;
   localparam int CODE_W    = 3;

   typedef enum logic [CODE_W-1:0] {
      SLP_RUN     = 3'b000,
      SLP_STOPCLK = 3'b001,
      SLP_DOZE    = 3'b010,
      SLP_RAM     = 3'b011,
      SLP_OFF     = 3'b100
   } slp_code_e;

   typedef struct packed {
      logic clk_stop;
      logic cpu_sleep;
      logic susp_ram;
      logic soft_off;
   } slp_out_t;
endpackage

// File: rtl/slp_ctrl_regs.sv
module slp_ctrl_regs
   import slp_type_pkg::*;
#(
   parameter int DW        = 16,
   parameter int AW        = 2,
   parameter int CTRL_ADDR = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     addr,
   input  logic [DW-1:0]     wr_data,
   output logic [DW-1:0]     rd_data,
   output logic [CODE_W-1:0] code_o,
   output logic              route_o,
   output logic              rel_o
);
   localparam int CODE_MSB = CODE_LSB + CODE_W - 1;
   localparam logic [AW-1:0] SEL_ADDR = AW'(CTRL_ADDR);

   logic              sel;
   logic              wr_hit;
   logic [CODE_W-1:0] code_q;
   logic              route_q;

   assign sel    = (addr == SEL_ADDR);
   assign wr_hit = wr_en & sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q  <= '0;
         route_q <= 1'b0;
      end else if (wr_hit) begin
         code_q  <= wr_data[CODE_MSB:CODE_LSB];
         route_q <= wr_data[ROUTE_BIT];
      end
   end

   assign rel_o   = wr_hit & wr_data[REL_BIT];
   assign code_o  = code_q;
   assign route_o = route_q;

   always_comb begin
      rd_data = '0;
      if (sel) begin
         rd_data[ROUTE_BIT]         = route_q;
         rd_data[CODE_MSB:CODE_LSB] = code_q;
      end
   end
endmodule

// File: rtl/slp_state_decode.sv
module slp_state_decode
   import slp_type_pkg::*;
(
   input  logic [CODE_W-1:0] code_i,
   output slp_out_t          out_o
);
   always_comb begin
      out_o = '0;
      case (code_i)
         SLP_STOPCLK: out_o.clk_stop = 1'b1;
         SLP_DOZE: begin
            out_o.clk_stop  = 1'b1;
            out_o.cpu_sleep = 1'b1;
         end
         SLP_RAM:  out_o.susp_ram = 1'b1;
         SLP_OFF:  out_o.soft_off = 1'b1;
         default:  out_o = '0;
      endcase
   end
endmodule

// File: rtl/slp_event_route.sv
module slp_event_route #(
   parameter int EVT_N    = 2,
   parameter bit EDGE_EVT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_N-1:0] evt_in,
   input  logic             route_sci,
   input  logic             rel_req,
   output logic             sci_req,
   output logic             smi_req
);
   logic hit;

   generate
      if (EDGE_EVT) begin : g_edge
         logic [EVT_N-1:0] evt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) evt_q <= '0;
            else        evt_q <= evt_in;
         end
         assign hit = |(evt_in & ~evt_q);
      end else begin : g_level
         assign hit = |evt_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sci_req <= 1'b0;
         smi_req <= 1'b0;
      end else begin
         sci_req <= route_sci & hit;
         smi_req <= (~route_sci & hit) | rel_req;
      end
   end
endmodule

// File: rtl/slp_type_ctrl.sv
module slp_type_ctrl
   import slp_type_pkg::*;
#(
   parameter int DW        = 16,
   parameter int AW        = 2,
   parameter int CTRL_ADDR = 0,
   parameter int EVT_N     = 2,
   parameter bit EDGE_EVT  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wr_data,
   output logic [DW-1:0]    rd_data,
   input  logic [EVT_N-1:0] evt_in,
   output logic             clk_stop_o,
   output logic             cpu_sleep_o,
   output logic             susp_ram_o,
   output logic             soft_off_o,
   output logic             sci_req_o,
   output logic             smi_req_o
);
   localparam int MIN_DW = CODE_LSB + CODE_W;

   generate
      if (DW < MIN_DW) begin : g_bad_dw
         $error("slp_type_ctrl: DW too narrow for control word");
      end
      if (EVT_N < 1) begin : g_bad_evt
         $error("slp_type_ctrl: EVT_N must be at least 1");
      end
      if (CTRL_ADDR >= (1 << AW)) begin : g_bad_addr
         $error("slp_type_ctrl: CTRL_ADDR outside address range");
      end
   endgenerate

   logic [CODE_W-1:0] code;
   logic              route;
   logic              rel;
   slp_out_t          slp;

   slp_ctrl_regs #(.DW(DW), .AW(AW), .CTRL_ADDR(CTRL_ADDR)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data),
      .code_o(code), .route_o(route), .rel_o(rel)
   );

   slp_state_decode u_dec (
      .code_i(code), .out_o(slp)
   );

   slp_event_route #(.EVT_N(EVT_N), .EDGE_EVT(EDGE_EVT)) u_route (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
      .route_sci(route), .rel_req(rel),
      .sci_req(sci_req_o), .smi_req(smi_req_o)
   );

   assign clk_stop_o  = slp.clk_stop;
   assign cpu_sleep_o = slp.cpu_sleep;
   assign susp_ram_o  = slp.susp_ram;
   assign soft_off_o  = slp.soft_off;
endmodule

// File: rtl/slp_type_ctrl_chk.sv
module slp_type_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] code,
   input logic       route,
   input logic       rel,
   input logic       clk_stop_o,
   input logic       cpu_sleep_o,
   input logic       susp_ram_o,
   input logic       soft_off_o,
   input logic       sci_req_o,
   input logic       smi_req_o
);
   a_r3_sleep_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_sleep_o |-> clk_stop_o);

   a_r2_one_state_group: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({clk_stop_o, susp_ram_o, soft_off_o}));

   a_r6_reserved_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (code > 3'd4) |-> !(clk_stop_o | cpu_sleep_o | susp_ram_o | soft_off_o));

   a_r8_sci_when_routed: assert property (@(posedge clk) disable iff (!rst_n)
      sci_req_o |-> $past(route));

   a_r9_smi_has_source: assert property (@(posedge clk) disable iff (!rst_n)
      smi_req_o |-> ($past(!route) || $past(rel)));
endmodule

bind slp_type_ctrl slp_type_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .code(code), .route(route), .rel(rel),
   .clk_stop_o(clk_stop_o), .cpu_sleep_o(cpu_sleep_o),
   .susp_ram_o(susp_ram_o), .soft_off_o(soft_off_o),
   .sci_req_o(sci_req_o), .smi_req_o(smi_req_o)
);

// File: tb/tb_slp_type_ctrl.sv
`timescale 1ns/1ps
module tb_slp_type_ctrl;
   localparam int DW = 16;
   localparam int AW = 2;
   localparam int EN = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic [EN-1:0] evt_in = '0;
   logic clk_stop_o, cpu_sleep_o, susp_ram_o, soft_off_o, sci_req_o, smi_req_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   slp_type_ctrl #(.DW(DW), .AW(AW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .evt_in(evt_in),
      .clk_stop_o(clk_stop_o), .cpu_sleep_o(cpu_sleep_o),
      .susp_ram_o(susp_ram_o), .soft_off_o(soft_off_o),
      .sci_req_o(sci_req_o), .smi_req_o(smi_req_o)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] ctrl_word(logic [2:0] code, logic route, logic rel);
      return {9'd0, code, 2'b00, rel, route};
   endfunction

   // expected sleep outputs {clk_stop,cpu_sleep,susp_ram,soft_off}
   function automatic logic [3:0] exp_slp(logic [2:0] code);
      case (code)
         3'd1: return 4'b1000;
         3'd2: return 4'b1100;
         3'd3: return 4'b0010;
         3'd4: return 4'b0001;
         default: return 4'b0000;
      endcase
   endfunction

   task automatic bus_write(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; addr = '0; wr_data = '0;
   endtask

   task automatic bus_read(logic [AW-1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rd_data;
      addr = '0;
   endtask

   task automatic t_reset;
      logic [DW-1:0] d;
      chk("R1 sleep outs", {clk_stop_o, cpu_sleep_o, susp_ram_o, soft_off_o}, 0);
      chk("R1 requests", {sci_req_o, smi_req_o}, 0);
      bus_read(0, d);
      chk("R1 readback", d, 0);
   endtask

   task automatic t_codes;
      logic [DW-1:0] d;
      for (int c = 0; c < 8; c++) begin
         bus_write(0, ctrl_word(3'(c), 1'b0, 1'b0));
         chk(c == 1 ? "R2 decode" : c == 2 ? "R3 decode" : c == 3 ? "R4 decode" :
             c >= 5 ? "R6 decode" : "R5 decode",
             {clk_stop_o, cpu_sleep_o, susp_ram_o, soft_off_o}, exp_slp(3'(c)));
         bus_read(0, d);
         chk(c >= 5 ? "R6 readback" : "R5 readback", d, ctrl_word(3'(c), 1'b0, 1'b0));
      end
   endtask

   task automatic t_release;
      logic [DW-1:0] d;
      bus_write(0, ctrl_word(3'd0, 1'b1, 1'b1));
      chk("R7 smi pulse", smi_req_o, 1);
      chk("R7 no sci", sci_req_o, 0);
      @(negedge clk);
      chk("R7 smi one cycle", smi_req_o, 0);
      bus_read(0, d);
      chk("R7 release reads 0", d, ctrl_word(3'd0, 1'b1, 1'b0));
   endtask

   task automatic t_route_sci;
      bus_write(0, ctrl_word(3'd0, 1'b1, 1'b0));
      evt_in = 2'b01;
      @(negedge clk);
      chk("R8 sci pulse", sci_req_o, 1);
      chk("R8 no smi", smi_req_o, 0);
      @(negedge clk);
      chk("R11 held no repeat", sci_req_o, 0);
      @(negedge clk);
      chk("R11 still quiet", sci_req_o, 0);
      evt_in = 2'b00;
      @(negedge clk);
      evt_in = 2'b10;
      @(negedge clk);
      chk("R11 re-arm pulse", sci_req_o, 1);
      evt_in = 2'b00;
      @(negedge clk);
   endtask

   task automatic t_route_smi;
      bus_write(0, ctrl_word(3'd0, 1'b0, 1'b0));
      evt_in = 2'b10;
      @(negedge clk);
      chk("R9 smi pulse", smi_req_o, 1);
      chk("R9 no sci", sci_req_o, 0);
      @(negedge clk);
      chk("R9 one cycle", smi_req_o, 0);
      evt_in = 2'b00;
      @(negedge clk);
   endtask

   task automatic t_other_addr;
      logic [DW-1:0] d;
      bus_write(0, ctrl_word(3'd3, 1'b1, 1'b0));
      bus_write(2, ctrl_word(3'd4, 1'b0, 1'b1));
      chk("R10 no smi from other addr", smi_req_o, 0);
      chk("R10 outputs kept", {clk_stop_o, cpu_sleep_o, susp_ram_o, soft_off_o}, 4'b0010);
      bus_read(0, d);
      chk("R10 fields kept", d, ctrl_word(3'd3, 1'b1, 1'b0));
      bus_read(1, d);
      chk("R10 other addr reads 0", d, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_codes();
      t_release();
      t_route_sci();
      t_route_smi();
      t_other_addr();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule